// File: doc/BRIEF.md
# Debounced Level Interrupt Controller

This block watches sixteen input-only pins. It filters each pin through its own millisecond debounce and raises a latched interrupt flag when the filtered level matches a chosen polarity. Software sees the block through a small 32-bit register bus with address, write enable, write data and read data. Per-channel registers pack channel n into bit n. A single registered interrupt line is the OR of every enabled flag.

Detection works on levels only. A channel looks for its level only after software writes a 1 to its trigger bit. That write restarts the channel's debounce and arms the detector once the debounce time has run out. A flag stays set until software clears it with a write-one clear. To emulate edge detection, software flips the polarity, clears the flag and re-triggers after each event.

Top module: `extint_ctrl`

## Requirements
- R1: Read data is registered. `busRdata` shows, one cycle after an address is presented, the value at that address. The trigger (0x28) and clear (0x24) addresses, and unmapped addresses, read as zero. Bits 31:16 of every per-channel register read as zero.
- R2: The control word of channel n sits at 0x40 + 4*n. It keeps all 32 written bits, and bits 11:0 give the debounce time in millisecond ticks.
- R3: Address 0x00 returns the filtered level of each channel ANDed with the read-enable mask held at 0x04. A channel whose mask bit is 0 reads 0.
- R4: With a debounce time of 0, the filtered level follows the two-flop synchronized pin. With a nonzero time D, a new level is taken only after it has held for D consecutive millisecond ticks, so a shorter pulse is dropped.
- R5: Writing 1 to bit n of 0x28 restarts channel n's debounce. It arms the channel only after D millisecond ticks. No flag is set on a channel that has not been armed.
- R6: Polarity at 0x14 selects active-high (1) or active-low (0). An armed channel whose filtered level equals its polarity sets its raw flag at 0x1C and disarms, so it gives one event per trigger. The flag stays set after the level goes inactive.
- R7: Writing 1 to bit n of 0x24 clears raw flag n. A 0 leaves it alone. A flag being set in the same cycle wins over its clear.
- R8: Address 0x20 returns the raw flags ANDed with the enable bits at 0x18. `irqOut` is the OR of those bits, one cycle later.
- R9: After reset all registers, flags and `irqOut` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pinIn | input | 16 | Asynchronous input pins, one per channel |
| busAddr | input | 8 | Byte address of the register access |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| irqOut | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with a millisecond tick every 4 clocks instead of the default 1000. Debounce times of 2 and 3 ticks therefore settle in a few dozen cycles. This brings within reach both a glitch shorter than the debounce window and an arming delay that leaves a trigger pending while reads observe it. Every other parameter keeps its default.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int CH_N   = 16;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DMASK = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_POL   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_IE    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_MIS   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_TRIG  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h40;

  // one-cycle command strobes from the register front end to the channels
  typedef struct packed {
    logic [CH_N-1:0] trig;
    logic [CH_N-1:0] clr;
  } strobe_t;
endpackage

// File: rtl/extint_regs.sv
module extint_regs import extint_pkg::*; #(
  parameter int DBNC_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic                         busWe,
  input  logic [REG_W-1:0]             busWdata,
  input  logic [CH_N-1:0]              filtLvl,
  input  logic [CH_N-1:0]              rawStat,
  output logic [REG_W-1:0]             busRdata,
  output strobe_t                      strb,
  output logic [CH_N-1:0]              dataMask,
  output logic [CH_N-1:0]              polSel,
  output logic [CH_N-1:0]              intEn,
  output logic [CH_N-1:0][DBNC_W-1:0]  dbncMs
);
  localparam int IDX_W    = (CH_N > 1) ? $clog2(CH_N) : 1;
  localparam int CTRL_END = int'(OFS_CTRL) + 4 * CH_N;

  logic [CH_N-1:0][REG_W-1:0] ctrlWord;
  logic                       ctrlHit;
  logic [ADDR_W-1:0]          ctrlOff;
  logic [IDX_W-1:0]           ctrlIdx;
  logic [REG_W-1:0]           rdNext;

  always_comb begin
    ctrlHit = (int'(busAddr) >= int'(OFS_CTRL)) && (int'(busAddr) < CTRL_END);
    ctrlOff = busAddr - OFS_CTRL;
    ctrlIdx = ctrlOff[IDX_W+1:2];
  end

  // command strobes live for exactly the write cycle
  always_comb begin
    strb.trig = (busWe && busAddr == OFS_TRIG) ? busWdata[CH_N-1:0] : '0;
    strb.clr  = (busWe && busAddr == OFS_CLR)  ? busWdata[CH_N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataMask <= '0;
      polSel   <= '0;
      intEn    <= '0;
      ctrlWord <= '0;
    end else if (busWe) begin
      case (busAddr)
        OFS_DMASK: dataMask <= busWdata[CH_N-1:0];
        OFS_POL:   polSel   <= busWdata[CH_N-1:0];
        OFS_IE:    intEn    <= busWdata[CH_N-1:0];
        default:   if (ctrlHit) ctrlWord[ctrlIdx] <= busWdata;
      endcase
    end
  end

  always_comb begin
    rdNext = '0;
    case (busAddr)
      OFS_DATA:  rdNext[CH_N-1:0] = filtLvl & dataMask;
      OFS_DMASK: rdNext[CH_N-1:0] = dataMask;
      OFS_POL:   rdNext[CH_N-1:0] = polSel;
      OFS_IE:    rdNext[CH_N-1:0] = intEn;
      OFS_RAW:   rdNext[CH_N-1:0] = rawStat;
      OFS_MIS:   rdNext[CH_N-1:0] = rawStat & intEn;
      default:   if (ctrlHit) rdNext = ctrlWord[ctrlIdx];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busRdata <= '0;
    else        busRdata <= rdNext;
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_dbnc
    assign dbncMs[g] = ctrlWord[g][DBNC_W-1:0];
  end
endmodule

// File: rtl/extint_core.sv
module extint_core import extint_pkg::*; #(
  parameter int TICK_DIV = 1000,
  parameter int DBNC_W   = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CH_N-1:0]              pinIn,
  input  strobe_t                      strb,
  input  logic [CH_N-1:0]              polSel,
  input  logic [CH_N-1:0]              intEn,
  input  logic [CH_N-1:0][DBNC_W-1:0]  dbncMs,
  output logic [CH_N-1:0]              filtLvl,
  output logic [CH_N-1:0]              rawStat,
  output logic [CH_N-1:0]              armedVec,
  output logic                         irqOut
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [TW-1:0]   tickCnt;
  logic            msTick;
  logic [CH_N-1:0] syncA, syncB;

  assign msTick = (tickCnt == TW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickCnt <= '0;
      syncA   <= '0;
      syncB   <= '0;
    end else begin
      tickCnt <= msTick ? '0 : tickCnt + 1'b1;
      syncA   <= pinIn;
      syncB   <= syncA;
    end
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    logic              filtQ, rawQ, armedQ, pendQ, hit;
    logic [DBNC_W-1:0] stabCnt, pendCnt;

    assign hit = armedQ && (filtQ == polSel[g]);

    // debounce filter
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        filtQ   <= 1'b0;
        stabCnt <= '0;
      end else if (strb.trig[g]) begin
        stabCnt <= '0;
      end else if (dbncMs[g] == '0) begin
        filtQ   <= syncB[g];
        stabCnt <= '0;
      end else if (syncB[g] == filtQ) begin
        stabCnt <= '0;
      end else if (msTick) begin
        if (stabCnt >= dbncMs[g] - 1'b1) begin
          filtQ   <= syncB[g];
          stabCnt <= '0;
        end else begin
          stabCnt <= stabCnt + 1'b1;
        end
      end
    end

    // arming sequencer: trigger -> wait debounce time -> armed -> one event
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pendQ   <= 1'b0;
        armedQ  <= 1'b0;
        pendCnt <= '0;
      end else if (strb.trig[g]) begin
        pendQ   <= 1'b1;
        armedQ  <= 1'b0;
        pendCnt <= '0;
      end else if (pendQ) begin
        if (pendCnt >= dbncMs[g]) begin
          pendQ  <= 1'b0;
          armedQ <= 1'b1;
        end else if (msTick) begin
          pendCnt <= pendCnt + 1'b1;
        end
      end else if (hit) begin
        armedQ <= 1'b0;
      end
    end

    // sticky flag, a new event beats a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rawQ <= 1'b0;
      else        rawQ <= hit | (rawQ & ~strb.clr[g]);
    end

    assign filtLvl[g]  = filtQ;
    assign rawStat[g]  = rawQ;
    assign armedVec[g] = armedQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqOut <= 1'b0;
    else        irqOut <= |(rawStat & intEn);
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl import extint_pkg::*; #(
  parameter int TICK_DIV = 1000,
  parameter int DBNC_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_N-1:0]   pinIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  output logic              irqOut
);
  strobe_t                     strb;
  logic [CH_N-1:0]             dataMask, polSel, intEn;
  logic [CH_N-1:0]             filtLvl, rawStat, armedVec;
  logic [CH_N-1:0][DBNC_W-1:0] dbncMs;

  extint_regs #(.DBNC_W(DBNC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .filtLvl(filtLvl), .rawStat(rawStat),
    .busRdata(busRdata), .strb(strb), .dataMask(dataMask),
    .polSel(polSel), .intEn(intEn), .dbncMs(dbncMs)
  );

  extint_core #(.TICK_DIV(TICK_DIV), .DBNC_W(DBNC_W)) u_core (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .strb(strb),
    .polSel(polSel), .intEn(intEn), .dbncMs(dbncMs),
    .filtLvl(filtLvl), .rawStat(rawStat), .armedVec(armedVec),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/extint_chk.sv
module extint_chk import extint_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic [REG_W-1:0]  busRdata,
  input logic              irqOut,
  input logic [CH_N-1:0]   rawStat,
  input logic [CH_N-1:0]   armedVec,
  input logic [CH_N-1:0]   clrMask,
  input logic [CH_N-1:0]   intEn,
  input logic [CH_N-1:0]   dataMask
);
  assert_cmd_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busAddr) == OFS_TRIG || $past(busAddr) == OFS_CLR) |-> busRdata == '0);

  assert_data_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busAddr) == OFS_DATA) |-> ((busRdata[CH_N-1:0] & ~$past(dataMask)) == '0));

  assert_only_armed_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rawStat & ~$past(rawStat) & ~$past(armedVec)) == '0));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~rawStat & $past(rawStat) & ~$past(clrMask)) == '0));

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqOut) |-> $past(|(rawStat & intEn)));

  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irqOut) |-> !$past(|(rawStat & intEn)));
endmodule

bind extint_ctrl extint_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busRdata(busRdata),
  .irqOut(irqOut), .rawStat(rawStat), .armedVec(armedVec),
  .clrMask(strb.clr), .intEn(intEn), .dataMask(dataMask)
);

// File: tb/sim_extint_ctrl.sv
module sim_extint_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pins = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  extint_ctrl #(.TICK_DIV(DIV), .DBNC_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .pinIn(pins), .busAddr(addr), .busWe(we),
    .busWdata(wdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference ----------------
  logic [15:0] mS1, mS2, mFilt, mArm, mPend, mRaw, mMask, mPol, mIe;
  logic [31:0] mCtrl [16];
  int          mStab [16];
  int          mPcnt [16];
  int          mTick;
  logic [31:0] mRd;
  logic        mIrq;

  function automatic logic [31:0] mRead(input logic [7:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 8'h00)      v[15:0] = mFilt & mMask;
    else if (a == 8'h04) v[15:0] = mMask;
    else if (a == 8'h14) v[15:0] = mPol;
    else if (a == 8'h18) v[15:0] = mIe;
    else if (a == 8'h1C) v[15:0] = mRaw;
    else if (a == 8'h20) v[15:0] = mRaw & mIe;
    else if (a >= 8'h40 && a < 8'h80) v = mCtrl[(a - 8'h40) / 4];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mS1 = '0; mS2 = '0; mFilt = '0; mArm = '0; mPend = '0; mRaw = '0;
      mMask = '0; mPol = '0; mIe = '0; mTick = 0; mRd = '0; mIrq = 1'b0;
      for (int n = 0; n < 16; n++) begin mCtrl[n] = '0; mStab[n] = 0; mPcnt[n] = 0; end
    end else begin
      bit tk;
      logic [15:0] tv, cv, nFilt, nArm, nPend, nRaw;
      tk = (mTick == DIV - 1);
      tv = (we && addr == 8'h28) ? wdata[15:0] : '0;
      cv = (we && addr == 8'h24) ? wdata[15:0] : '0;
      mIrq = |(mRaw & mIe);
      mRd = mRead(addr);
      nFilt = mFilt; nArm = mArm; nPend = mPend; nRaw = mRaw;
      for (int n = 0; n < 16; n++) begin
        int d;
        bit hit;
        d = int'(mCtrl[n][11:0]);
        hit = mArm[n] && (mFilt[n] == mPol[n]);
        if (tv[n]) mStab[n] = 0;
        else if (d == 0) begin nFilt[n] = mS2[n]; mStab[n] = 0; end
        else if (mS2[n] == mFilt[n]) mStab[n] = 0;
        else if (tk) begin
          if (mStab[n] + 1 >= d) begin nFilt[n] = mS2[n]; mStab[n] = 0; end
          else mStab[n] = mStab[n] + 1;
        end
        if (tv[n]) begin nPend[n] = 1'b1; nArm[n] = 1'b0; mPcnt[n] = 0; end
        else if (mPend[n]) begin
          if (mPcnt[n] >= d) begin nPend[n] = 1'b0; nArm[n] = 1'b1; end
          else if (tk) mPcnt[n] = mPcnt[n] + 1;
        end else if (hit) nArm[n] = 1'b0;
        nRaw[n] = hit || (mRaw[n] && !cv[n]);
      end
      mFilt = nFilt; mArm = nArm; mPend = nPend; mRaw = nRaw;
      mS2 = mS1; mS1 = pins;
      mTick = tk ? 0 : mTick + 1;
      if (we) begin
        if (addr == 8'h04) mMask = wdata[15:0];
        else if (addr == 8'h14) mPol = wdata[15:0];
        else if (addr == 8'h18) mIe = wdata[15:0];
        else if (addr >= 8'h40 && addr < 8'h80) mCtrl[(addr - 8'h40) / 4] = wdata;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 read data vs model", busRdata, mRd);
      check("R8 irqOut vs model", {31'd0, irqOut}, {31'd0, mIrq});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); d = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    idle(5);
    rst_n = 1'b1;
    idle(2);
    // R9 reset state
    check("R9 irqOut after reset", {31'd0, irqOut}, 32'd0);
    rd(8'h00, v); check("R9 data after reset", v, 32'h0);
    rd(8'h18, v); check("R9 enable after reset", v, 32'h0);
    // R2 control word storage
    wr(8'h4C, 32'hABCD5005);
    rd(8'h4C, v); check("R2 ctrl word readback", v, 32'hABCD5005);
    wr(8'h4C, 32'h0);
    // R1 upper bits, command and unmapped addresses
    wr(8'h04, 32'hFFFFFFFF);
    rd(8'h04, v); check("R1 upper bits zero", v, 32'h0000FFFF);
    rd(8'h28, v); check("R1 trigger reads zero", v, 32'h0);
    rd(8'h24, v); check("R1 clear reads zero", v, 32'h0);
    rd(8'h08, v); check("R1 unmapped reads zero", v, 32'h0);
    // R3 masked data, R4 zero debounce
    pins = 16'h0FA5;
    wr(8'h04, 32'h000000FF);
    idle(5);
    rd(8'h00, v); check("R3 masked data", v, 32'h000000A5);
    pins = 16'h0FA4;
    idle(4);
    rd(8'h00, v); check("R4 zero debounce follows pin", v, 32'h000000A4);
    // R4 nonzero debounce on channel 5 (3 ticks)
    wr(8'h04, 32'h0000FFFF);
    wr(8'h54, 32'd3);
    pins = 16'h0F84;
    idle(3);
    rd(8'h00, v); check("R4 level held before debounce", {31'd0, v[5]}, 32'd1);
    idle(20);
    rd(8'h00, v); check("R4 level taken after debounce", {31'd0, v[5]}, 32'd0);
    pins = 16'h0FA4;
    idle(6);
    pins = 16'h0F84;
    idle(20);
    rd(8'h00, v); check("R4 short glitch dropped", {31'd0, v[5]}, 32'd0);
    wr(8'h54, 32'd0);
    // R5 no flag without trigger
    wr(8'h14, 32'h00000004);
    idle(10);
    rd(8'h1C, v); check("R5 no flag before trigger", v, 32'h0);
    wr(8'h28, 32'h00000004);
    idle(4);
    rd(8'h1C, v); check("R6 active-high event", v, 32'h00000004);
    // R6 sticky
    pins = 16'h0F80;
    idle(5);
    rd(8'h1C, v); check("R6 flag sticky after level drops", v, 32'h00000004);
    // R8 masking and irq
    rd(8'h20, v); check("R8 masked zero when disabled", v, 32'h0);
    check("R8 irq low when disabled", {31'd0, irqOut}, 32'd0);
    wr(8'h18, 32'h00000004);
    idle(2);
    check("R8 irq high when enabled", {31'd0, irqOut}, 32'd1);
    rd(8'h20, v); check("R8 masked status", v, 32'h00000004);
    // R7 write-one clear
    wr(8'h24, 32'h00000000);
    rd(8'h1C, v); check("R7 zero write keeps flag", v, 32'h00000004);
    wr(8'h24, 32'h00000004);
    rd(8'h1C, v); check("R7 one write clears flag", v, 32'h0);
    idle(1);
    check("R8 irq drops after clear", {31'd0, irqOut}, 32'd0);
    // R6 one event per trigger
    pins = 16'h0F84;
    idle(8);
    rd(8'h1C, v); check("R6 disarmed after event", v, 32'h0);
    // R6 active-low on channel 7
    pins = 16'h0F04;
    idle(4);
    wr(8'h28, 32'h00000080);
    idle(4);
    rd(8'h1C, v); check("R6 active-low event", v, 32'h00000080);
    // R5 arming waits for debounce time on channel 9
    wr(8'h14, 32'h00000204);
    wr(8'h64, 32'd2);
    wr(8'h28, 32'h00000200);
    rd(8'h1C, v); check("R5 still pending", v, 32'h00000080);
    idle(15);
    rd(8'h1C, v); check("R5 armed after debounce", v, 32'h00000280);
    wr(8'h24, 32'h0000FFFF);
    rd(8'h1C, v); check("R7 clear all", v, 32'h0);
    idle(2);
    finishRun();
  end
endmodule